// File: doc/BRIEF.md
# Fixed-point 8x8 forward DCT coprocessor

This block is a memory-mapped coprocessor that performs a two-dimensional forward discrete cosine transform on one 8x8 block of signed 8-bit samples. It uses integer arithmetic with six fractional bits and a truncating arithmetic right shift after every product. A host pushes 64 samples into a data-in register, writes 1 to a command register, polls a status register until the block reports ready, and then pops 64 signed 16-bit coefficients from a data-out register.

The transform is separable. A row pass forms 64 partial sums, one for each (row, frequency) pair, and stores them in a local table. A column pass then combines eight of these per coefficient and applies the normalisation. One multiply-accumulate unit serves both passes, so a transform takes 1024 cycles. Both the input and output buffers share one pointer, and that pointer returns to entry 0 when a transform completes.

Top module: `fdct8_copro`

## Requirements
- R1: After reset, status bit 0 reads 1 (ready) and all 64 data-out entries read 0.
- R2: Register select `addr_i` takes these values: 0 is data-in, 1 is data-out, 2 is command and 3 is status. A write to data-in while idle stores `wdata_i[7:0]`, taken as signed and scaled by 64, at the shared pointer, then advances the pointer. The 65th write wraps the pointer and overwrites entry 0. Entry index is row*8+column.
- R3: Writing exactly 1 to the command register while idle starts a transform. Any other value leaves the block idle.
- R4: Status bit 0 reads 0 from the cycle after a start until the last coefficient is written. It reads 1 again no more than 1100 cycles after the start.
- R5: Coefficient (u,v) is computed as follows. The cosine table is c[j][k] = trunc(64*cos((2j+1)*k*pi/16)), so row 0 is 64, 62, 59, 53, 45, 35, 24, 12. The row terms are s[x][v] = sum over j of (64*p[x][j]*c[j][v]) >>> 6. The column sum is r = sum over x of (s[x][v]*c[x][u]) >>> 6. With a(0)=45 and a(h>0)=64, let g = ((((16*a(u))>>>6)*a(v))>>>6). The result is ((r*g)>>>6)>>>6, truncated to signed 16 bits.
- R6: When a transform completes, the shared pointer returns to 0. Each read of data-out while idle returns the entry at the pointer and advances the pointer, giving coefficient u*8+v in order. The 65th read wraps to entry 0.
- R7: Writes to data-in while a transform runs are ignored. They change neither the input buffer nor the pointer.
- R8: Reads of data-out while a transform runs return 0 and do not advance the pointer.
- R9: Reads of the data-in and command addresses return 0. Status reads return 0 in bits 15:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe; data appears on rdata_o after the next edge |
| addr_i | input | 2 | Register select (0 data-in, 1 data-out, 2 command, 3 status) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |

## Verification
The hardest situation to reach is host traffic that arrives while a transform runs. Stray pushes and pops in that window must leave both the input buffer and the shared pointer untouched, and the visible evidence only appears a thousand cycles later. The stimulus therefore starts a transform and at once issues junk pushes and early pops. It then checks that every coefficient, read from pointer 0, matches the original block. A second start with no new pushes must reproduce the same result. Separate cases push a 65th sample and pop a 65th coefficient to exercise the wrap of the shared pointer. These run alongside seeded random blocks and extreme constant, checkerboard and impulse blocks.

// File: rtl/fdct8_pkg.sv
package fdct8_pkg;
  localparam int BLK_N     = 8;
  localparam int BLK_SIZE  = BLK_N * BLK_N;
  localparam int IDX_W     = $clog2(BLK_SIZE);
  localparam int POS_W     = $clog2(BLK_N);
  localparam int FRAC_BITS = 6;
  localparam int COEF_W    = 8;
  localparam int C0_Q6     = 45;

  typedef enum logic [1:0] {
    REG_DIN  = 2'd0,
    REG_DOUT = 2'd1,
    REG_CMD  = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_COL  = 2'd2
  } eng_state_e;

  // Q6 cosine of (2*pos+1)*freq*pi/16, built from a quarter-wave table
  function automatic logic signed [COEF_W-1:0] cos_q6(input logic [POS_W-1:0] pos,
                                                      input logic [POS_W-1:0] freq);
    int m, k, mag;
    logic neg;
    m = ((2 * int'(pos) + 1) * int'(freq)) % 32;
    if (m <= 8)       begin k = m;      neg = 1'b0; end
    else if (m < 16)  begin k = 16 - m; neg = 1'b1; end
    else if (m <= 24) begin k = m - 16; neg = 1'b1; end
    else              begin k = 32 - m; neg = 1'b0; end
    case (k)
      0: mag = 64;
      1: mag = 62;
      2: mag = 59;
      3: mag = 53;
      4: mag = 45;
      5: mag = 35;
      6: mag = 24;
      7: mag = 12;
      default: mag = 0;
    endcase
    return neg ? COEF_W'(-mag) : COEF_W'(mag);
  endfunction
endpackage

// File: rtl/fdct8_mac.sv
module fdct8_mac
  import fdct8_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     last_i,
  input  logic signed [ACC_W-1:0]  op_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic signed [ACC_W-1:0]  sum_o
);
  localparam int PROD_W = ACC_W + COEF_W;

  logic signed [ACC_W-1:0]  acc_q;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  term;

  always_comb begin
    prod  = op_i * coef_i;
    term  = ACC_W'(prod >>> FRAC_BITS);
    sum_o = acc_q + term;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (en_i)   acc_q <= last_i ? '0 : sum_o;
  end
endmodule

// File: rtl/fdct8_scale.sv
module fdct8_scale
  import fdct8_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int DATA_W = 16
) (
  input  logic signed [ACC_W-1:0]  r_i,
  input  logic [POS_W-1:0]         u_i,
  input  logic [POS_W-1:0]         v_i,
  output logic signed [DATA_W-1:0] coef_o
);
  localparam int PROD_W = ACC_W + COEF_W;

  int cu, cv, kq, kuv;
  logic signed [COEF_W-1:0] gain;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;

  always_comb begin
    cu      = (u_i == '0) ? C0_Q6 : 64;
    cv      = (v_i == '0) ? C0_Q6 : 64;
    kq      = (16 * cu) >>> FRAC_BITS;
    kuv     = (kq * cv) >>> FRAC_BITS;
    gain    = COEF_W'(kuv);
    prod    = r_i * gain;
    shifted = (prod >>> FRAC_BITS) >>> FRAC_BITS;
    coef_o  = DATA_W'(shifted);
  end
endmodule

// File: rtl/fdct8_engine.sv
module fdct8_engine
  import fdct8_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 32,
  parameter int DATA_W   = 16,
  localparam int IN_W    = SAMPLE_W + FRAC_BITS
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [IDX_W-1:0]         in_idx_o,
  input  logic signed [IN_W-1:0]   in_data_i,
  output logic                     out_we_o,
  output logic [IDX_W-1:0]         out_idx_o,
  output logic signed [DATA_W-1:0] out_data_o
);
  localparam logic [IDX_W-1:0] ENT_LAST = IDX_W'(BLK_SIZE - 1);
  localparam logic [POS_W-1:0] K_LAST   = POS_W'(BLK_N - 1);

  eng_state_e               state_q;
  logic [IDX_W-1:0]         ent_q;
  logic [POS_W-1:0]         k_q;
  logic signed [ACC_W-1:0]  s_mem [BLK_SIZE];

  logic [POS_W-1:0]         hi_pos, lo_pos;
  logic signed [ACC_W-1:0]  op;
  logic signed [COEF_W-1:0] coef;
  logic signed [ACC_W-1:0]  sum;
  logic                     last_k;

  assign hi_pos = ent_q[IDX_W-1:POS_W];
  assign lo_pos = ent_q[POS_W-1:0];
  assign last_k = (k_q == K_LAST);

  // row pass: entry {x,v}, k walks columns j; column pass: entry {u,v}, k walks rows x
  always_comb begin
    in_idx_o = {hi_pos, k_q};
    if (state_q == ST_COL) begin
      op   = s_mem[{k_q, lo_pos}];
      coef = cos_q6(k_q, hi_pos);
    end else begin
      op   = ACC_W'(in_data_i);
      coef = cos_q6(k_q, lo_pos);
    end
  end

  fdct8_mac #(.ACC_W(ACC_W)) u_mac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy_o),
    .last_i (last_k),
    .op_i   (op),
    .coef_i (coef),
    .sum_o  (sum)
  );

  fdct8_scale #(.ACC_W(ACC_W), .DATA_W(DATA_W)) u_scale (
    .r_i    (sum),
    .u_i    (hi_pos),
    .v_i    (lo_pos),
    .coef_o (out_data_o)
  );

  assign busy_o    = (state_q != ST_IDLE);
  assign out_we_o  = (state_q == ST_COL) && last_k;
  assign out_idx_o = ent_q;
  assign done_o    = out_we_o && (ent_q == ENT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ent_q   <= '0;
      k_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ROW;
          ent_q   <= '0;
          k_q     <= '0;
        end
        ST_ROW, ST_COL: begin
          k_q <= k_q + 1'b1;
          if (last_k) begin
            ent_q <= ent_q + 1'b1;
            if (ent_q == ENT_LAST)
              state_q <= (state_q == ST_ROW) ? ST_COL : ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (state_q == ST_ROW && last_k) s_mem[ent_q] <= sum;
  end

  // R4: the last coefficient write ends the busy period
  a_r4_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  // R3: a start from idle begins with the row pass, no output write yet
  a_r3_start_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !out_we_o));

  // R5: output writes only come after a full row pass
  a_r5_col_follows_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_we_o && ent_q == '0) |-> ($past(state_q) != ST_IDLE));
endmodule

// File: rtl/fdct8_copro.sv
module fdct8_copro
  import fdct8_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int DATA_W   = 16,
  parameter int ACC_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IN_W = SAMPLE_W + FRAC_BITS;

  reg_sel_e                 sel;
  logic                     busy, done, push, pop, start;
  logic [IDX_W-1:0]         idx_q;
  logic signed [IN_W-1:0]   in_mem  [BLK_SIZE];
  logic signed [DATA_W-1:0] out_mem [BLK_SIZE];
  logic [IDX_W-1:0]         eng_in_idx, eng_out_idx;
  logic                     eng_out_we;
  logic signed [DATA_W-1:0] eng_out_data;
  logic signed [SAMPLE_W-1:0] sample;
  logic [DATA_W-1:0]        rdata_q;

  assign sel    = reg_sel_e'(addr_i);
  assign push   = wr_i && (sel == REG_DIN) && !busy;
  assign pop    = rd_i && (sel == REG_DOUT) && !busy;
  assign start  = wr_i && (sel == REG_CMD) && !busy && (wdata_i == DATA_W'(1));
  assign sample = wdata_i[SAMPLE_W-1:0];

  fdct8_engine #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .DATA_W(DATA_W)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .busy_o     (busy),
    .done_o     (done),
    .in_idx_o   (eng_in_idx),
    .in_data_i  (in_mem[eng_in_idx]),
    .out_we_o   (eng_out_we),
    .out_idx_o  (eng_out_idx),
    .out_data_o (eng_out_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            idx_q <= '0;
    else if (done)          idx_q <= '0;
    else if (push || pop)   idx_q <= idx_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push) in_mem[idx_q] <= IN_W'(sample) <<< FRAC_BITS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BLK_SIZE; i++) out_mem[i] <= '0;
    end else if (eng_out_we) begin
      out_mem[eng_out_idx] <= eng_out_data;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_i) begin
      case (sel)
        REG_DOUT: rdata_q <= pop ? out_mem[idx_q] : '0;
        REG_STAT: rdata_q <= {{(DATA_W-1){1'b0}}, !busy};
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;

  // R7: pushes during a transform leave the pointer alone
  a_r7_push_ignored_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done && wr_i && sel == REG_DIN) |=> (idx_q == $past(idx_q)));

  // R8: pops during a transform return zero
  a_r8_pop_busy_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && rd_i && sel == REG_DOUT) |=> (rdata_o == '0));

  // R6: pointer is back at entry 0 after completion
  a_r6_idx_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (idx_q == '0));

  // R3: only the value 1 starts a transform
  a_r3_bad_cmd_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel == REG_CMD && wdata_i != DATA_W'(1) && !busy) |=> !busy);

  // R9: status upper bits stay clear
  a_r9_stat_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel == REG_STAT) |=> (rdata_o[DATA_W-1:1] == '0));
endmodule

// File: tb/fdct8_copro_tb_top.sv
`timescale 1ns/1ps
module fdct8_copro_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int checks = 0;
  int fails  = 0;
  int blk   [64];
  int exp_c [64];

  always #10 clk = ~clk;

  fdct8_copro dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_i    (wr),
    .rd_i    (rd),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  function automatic int cq(input int j, input int k);
    real a;
    a = 64.0 * $cos(3.14159265358979 * real'(((2*j+1)*k) % 32) / 16.0);
    return $rtoi(a + ((a >= 0.0) ? 1.0e-6 : -1.0e-6));
  endfunction

  function automatic void compute_model();
    longint s [8][8];
    for (int x = 0; x < 8; x++)
      for (int v = 0; v < 8; v++) begin
        s[x][v] = 0;
        for (int j = 0; j < 8; j++)
          s[x][v] += (longint'(blk[x*8+j] * 64) * cq(j, v)) >>> 6;
      end
    for (int u = 0; u < 8; u++)
      for (int v = 0; v < 8; v++) begin
        longint r, val;
        int au, av, g;
        r = 0;
        for (int x = 0; x < 8; x++) r += (s[x][v] * cq(x, u)) >>> 6;
        au = (u == 0) ? 45 : 64;
        av = (v == 0) ? 45 : 64;
        g  = (((16 * au) >>> 6) * av) >>> 6;
        val = ((r * g) >>> 6) >>> 6;
        exp_c[u*8+v] = int'(shortint'(val));
      end
  endfunction

  task automatic push_block();
    for (int i = 0; i < 64; i++) bus_write(2'd0, 16'(blk[i]));
  endtask

  task automatic wait_ready(input string req);
    logic [15:0] d;
    int n;
    n = 0;
    do begin
      bus_read(2'd3, d);
      n++;
    end while (d[0] == 1'b0 && n < 2000);
    check(n * 2 <= 1100, req, n * 2, 1100);
  endtask

  task automatic pop_compare(input string req);
    logic [15:0] d;
    for (int i = 0; i < 64; i++) begin
      bus_read(2'd1, d);
      check(int'($signed(d)) == exp_c[i], req, int'($signed(d)), exp_c[i]);
    end
  endtask

  task automatic run_block(input string req);
    logic [15:0] d;
    compute_model();
    push_block();
    bus_write(2'd2, 16'd1);
    bus_read(2'd3, d);
    check(d == 16'd0, "R4 busy after start", int'(d), 0);
    wait_ready("R4 ready bound");
    pop_compare(req);
  endtask

  initial begin
    logic [15:0] d;
    int dummy;
    dummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(2'd3, d);
    check(d == 16'd1, "R1 status ready", int'(d), 1);
    for (int i = 0; i < 64; i++) begin
      bus_read(2'd1, d);
      check(d == 16'd0, "R1 dout zero", int'(d), 0);
    end
    // R9 non-readable addresses
    bus_read(2'd0, d);
    check(d == 16'd0, "R9 din read", int'(d), 0);
    bus_read(2'd2, d);
    check(d == 16'd0, "R9 cmd read", int'(d), 0);

    // R3 other command values do nothing
    bus_write(2'd2, 16'd2);
    bus_read(2'd3, d);
    check(d == 16'd1, "R3 cmd 2 ignored", int'(d), 1);
    bus_write(2'd2, 16'd0);
    bus_read(2'd3, d);
    check(d == 16'd1, "R3 cmd 0 ignored", int'(d), 1);

    // R5 random blocks
    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(255)) - 128;
      run_block("R5 random block");
    end
    // R5 directed corners
    for (int i = 0; i < 64; i++) blk[i] = 127;
    run_block("R5 const max");
    for (int i = 0; i < 64; i++) blk[i] = -128;
    run_block("R5 const min");
    for (int i = 0; i < 64; i++) blk[i] = 0;
    run_block("R5 zero");
    for (int i = 0; i < 64; i++) blk[i] = (((i / 8) + (i % 8)) % 2 != 0) ? 127 : -128;
    run_block("R5 checkerboard");
    for (int i = 0; i < 64; i++) blk[i] = (i == 0) ? 100 : 0;
    run_block("R5 R6 impulse");
    for (int i = 0; i < 64; i++) blk[i] = (i % 8) * 16 - 60;
    run_block("R5 row ramp");

    // R7 R8 host traffic during a transform
    for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(255)) - 128;
    compute_model();
    push_block();
    bus_write(2'd2, 16'd1);
    for (int i = 0; i < 10; i++) bus_write(2'd0, 16'h0055);
    bus_read(2'd1, d);
    check(d == 16'd0, "R8 pop while busy", int'(d), 0);
    bus_read(2'd1, d);
    check(d == 16'd0, "R8 pop while busy", int'(d), 0);
    wait_ready("R4 ready bound");
    pop_compare("R7 R8 busy traffic ignored");
    bus_write(2'd2, 16'd1);
    wait_ready("R4 ready bound");
    pop_compare("R7 input buffer kept");

    // R2 65th push overwrites entry 0
    for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(255)) - 128;
    push_block();
    bus_write(2'd0, 16'hFF9C);
    blk[0] = -100;
    compute_model();
    bus_write(2'd2, 16'd1);
    wait_ready("R4 ready bound");
    pop_compare("R2 R6 push wrap");

    // R6 65th pop wraps to entry 0
    bus_read(2'd1, d);
    check(int'($signed(d)) == exp_c[0], "R6 pop wrap", int'($signed(d)), exp_c[0]);

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule